// File: doc/BRIEF.md
# Shared-Term Symmetric Constant FIR Filter

This block is an 11-tap symmetric low-pass FIR filter with fixed integer coefficients. It contains no general multiplier. Each accepted sample is first scaled into a small shared set of terms: the sample itself and three times the sample. Each of the six distinct coefficient products is then built from shifted copies of those shared terms. One product is built by adding two other products, so the whole product section uses six adders in total. A transposed register array adds the products after the right number of sample delays. The result is exact and is output at full width.

The impulse response is 2, 7, 18, 34, 50, 57, 50, 34, 18, 7, 2. Registers are placed so that no path between two registers passes through more than one adder. Samples arrive on a valid/ready stream and results leave on a valid/ready stream.

The whole pipeline advances together, so back-pressure works as follows:
- The block advances whenever its output register is empty or the consumer is ready.
- `in_ready` is exactly this advance condition.
- A stalled result stays on the output unchanged until it is taken.

Top module: `shared_term_fir`

## Requirements
- R1: Every output equals y[n] = sum over k of h[k]*x[n-k], with h = {2,7,18,34,50,57,50,34,18,7,2}. Here x[n-k] is the k-th most recent accepted sample, and samples before reset count as zero. `in_data` is 12-bit two's complement and `out_data` is 24-bit two's complement.
- R2: The shared stage registers the sample and three times the sample, formed as x + 2x with a single adder.
- R3: Each stage-2 product row equals the sample times its coefficient (rows 0..4 = 2, 7, 18, 34, 50). These rows are made from shifted shared terms. The row for 57 is the sum of the 50 row and the 7 row, so all rows stay in the same ratio as their coefficients.
- R4: Without stalls, a sample accepted at one rising edge produces its `out_valid` result after the fourth rising edge, counting that edge.
- R5: Only accepted samples (`in_valid` and `in_ready` both high) advance the delay line. Idle cycles change neither the results nor their order. Each accepted sample yields exactly one output.
- R6: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_data` hold their values.
- R7: A synchronous active-high `rst` clears all pipeline and tap registers. After reset, `out_valid` and `out_data` are 0 and `in_ready` is 1, and later outputs treat all earlier samples as zero.
- R8: Full-scale inputs (+2047 and -2048, repeated over all taps) give exact results of ±279 times the sample, without wrap-around.
- R9: A unit impulse reproduces the 11 coefficients in tap order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on `in_data` |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | Filtered result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 24 | Signed filtered result |

## Verification
The bench builds the block with its default widths: 12-bit samples, 20-bit products and a 24-bit accumulator. Full-scale samples therefore reach the top bits of both the product rows (57 × −2048) and the accumulator (279 × −2048), and any missing sign extension shows up as a wrong result. A table covers the impulse and the step. The bench's own convolution model then scores random samples under idle input cycles and random output stalls. Directed tests cover the four-edge latency and a reset issued while results are still in flight.

// File: rtl/scfir_pkg.sv
package scfir_pkg;
  localparam int TAPS        = 11;
  localparam int ROWS        = (TAPS + 1) / 2;
  localparam int DIRECT_ROWS = ROWS - 1;
  localparam int REUSE_ROW   = ROWS - 1;
  localparam int REUSE_A     = 4;
  localparam int REUSE_B     = 1;
  localparam int SHW         = 3;

  // One row of the private matrix: term A plus/minus optional term B.
  // src = 0 selects x, src = 1 selects 3x.
  typedef struct packed {
    logic           src_a;
    logic [SHW-1:0] sh_a;
    logic           use_b;
    logic           src_b;
    logic [SHW-1:0] sh_b;
    logic           neg_b;
  } row_t;

  function automatic row_t private_row(input int r);
    row_t v;
    v = '0;
    case (r)
      0: begin v.src_a = 1'b0; v.sh_a = 3'd1; end
      1: begin v.src_a = 1'b1; v.sh_a = 3'd1; v.use_b = 1'b1; v.src_b = 1'b0; v.sh_b = 3'd0; end
      2: begin v.src_a = 1'b1; v.sh_a = 3'd2; v.use_b = 1'b1; v.src_b = 1'b1; v.sh_b = 3'd1; end
      3: begin v.src_a = 1'b0; v.sh_a = 3'd5; v.use_b = 1'b1; v.src_b = 1'b0; v.sh_b = 3'd1; end
      4: begin v.src_a = 1'b1; v.sh_a = 3'd4; v.use_b = 1'b1; v.src_b = 1'b0; v.sh_b = 3'd1; end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic int coef_of_row(input int r);
    case (r)
      0: return 2;
      1: return 7;
      2: return 18;
      3: return 34;
      4: return 50;
      default: return 57;
    endcase
  endfunction

  function automatic int tap_row(input int k);
    return (k < ROWS) ? k : (TAPS - 1 - k);
  endfunction
endpackage

// File: rtl/scfir_public.sv
module scfir_public #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 vld_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW+1:0] x3_o
);
  localparam int XW3 = DW + 2;

  logic signed [XW3-1:0] x_ext, x_dbl, x3_d;

  assign x_ext = {{2{in_data[DW-1]}}, in_data};
  assign x_dbl = {in_data[DW-1], in_data, 1'b0};
  assign x3_d  = x_ext + x_dbl;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      x_o   <= '0;
      x3_o  <= '0;
    end else if (adv) begin
      vld_o <= in_valid;
      x_o   <= in_data;
      x3_o  <= x3_d;
    end
  end

  assert_triple_term_R2: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (int'($signed(x3_o)) == 3 * int'($signed(x_o))));
endmodule

// File: rtl/scfir_private.sv
module scfir_private
  import scfir_pkg::*;
#(
  parameter int DW = 12,
  parameter int PW = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      adv,
  input  logic                      vld_i,
  input  logic signed [DW-1:0]      x_i,
  input  logic signed [DW+1:0]      x3_i,
  output logic                      vld_o,
  output logic [ROWS-1:0][PW-1:0]   prod_o
);
  logic signed [PW-1:0] xs, x3s;
  logic [PW-1:0] p2_d [DIRECT_ROWS];
  logic [PW-1:0] p2_q [DIRECT_ROWS];
  logic [PW-1:0] p3_d [ROWS];
  logic [PW-1:0] p3_q [ROWS];
  logic          vld2_q;

  assign xs  = {{(PW-DW){x_i[DW-1]}}, x_i};
  assign x3s = {{(PW-DW-2){x3_i[DW+1]}}, x3_i};

  // Stage 2: one shift-add per row from the shared terms.
  for (genvar r = 0; r < DIRECT_ROWS; r++) begin : g_row
    localparam row_t RW = private_row(r);
    localparam int   C  = coef_of_row(r);
    logic signed [PW-1:0] ta;
    assign ta = (RW.src_a ? x3s : xs) <<< RW.sh_a;
    if (RW.use_b) begin : g_two
      logic signed [PW-1:0] tb;
      assign tb = (RW.src_b ? x3s : xs) <<< RW.sh_b;
      if (RW.neg_b) begin : g_sub
        assign p2_d[r] = ta - tb;
      end else begin : g_add
        assign p2_d[r] = ta + tb;
      end
    end else begin : g_one
      assign p2_d[r] = ta;
    end

    assert_row_product_R3: assert property (@(posedge clk) disable iff (rst)
      (adv && vld_i) |=> (int'($signed(p2_q[r])) == int'($past(x_i)) * C));
  end

  // Stage 3: align direct rows, build the reused row from two products.
  for (genvar r = 0; r < ROWS; r++) begin : g_align
    if (r == REUSE_ROW) begin : g_reuse
      assign p3_d[r] = p2_q[REUSE_A] + p2_q[REUSE_B];
    end else begin : g_pass
      assign p3_d[r] = p2_q[r];
    end
    assign prod_o[r] = p3_q[r];

    assert_row_ratio_R3: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> (int'($signed(p3_q[r])) * coef_of_row(1) ==
                 int'($signed(p3_q[1])) * coef_of_row(r)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld2_q <= 1'b0;
      vld_o  <= 1'b0;
      for (int r = 0; r < DIRECT_ROWS; r++) p2_q[r] <= '0;
      for (int r = 0; r < ROWS; r++) p3_q[r] <= '0;
    end else if (adv) begin
      vld2_q <= vld_i;
      vld_o  <= vld2_q;
      for (int r = 0; r < DIRECT_ROWS; r++) p2_q[r] <= p2_d[r];
      for (int r = 0; r < ROWS; r++) p3_q[r] <= p3_d[r];
    end
  end
endmodule

// File: rtl/scfir_taps.sv
module scfir_taps
  import scfir_pkg::*;
#(
  parameter int PW = 20,
  parameter int AW = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    vld_i,
  input  logic [ROWS-1:0][PW-1:0] prod_i,
  output logic                    vld_o,
  output logic [AW-1:0]           y_o
);
  logic [AW-1:0] z_d [TAPS];
  logic [AW-1:0] z_q [TAPS];
  logic          fire;

  assign fire = adv && vld_i;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam int ROW = tap_row(k);
    logic [AW-1:0] ext;
    assign ext = {{(AW-PW){prod_i[ROW][PW-1]}}, prod_i[ROW]};
    if (k == TAPS - 1) begin : g_last
      assign z_d[k] = ext;
    end else begin : g_mid
      assign z_d[k] = ext + z_q[k+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      for (int k = 0; k < TAPS; k++) z_q[k] <= '0;
    end else begin
      if (adv) vld_o <= vld_i;
      if (fire) begin
        for (int k = 0; k < TAPS; k++) z_q[k] <= z_d[k];
      end
    end
  end

  assign y_o = z_q[0];

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (vld_o && !adv) |=> (vld_o && $stable(z_q[0])));

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (!vld_o && (z_q[0] == '0) && (z_q[TAPS-1] == '0)));
endmodule

// File: rtl/shared_term_fir.sv
module shared_term_fir
  import scfir_pkg::*;
#(
  parameter int DW = 12,
  parameter int PW = 20,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data
);
  logic                    adv;
  logic                    vld1, vld3;
  logic signed [DW-1:0]    x1;
  logic signed [DW+1:0]    x3;
  logic [ROWS-1:0][PW-1:0] prods;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  scfir_public #(.DW(DW)) u_public (
    .clk(clk), .rst(rst), .adv(adv),
    .in_valid(in_valid), .in_data($signed(in_data)),
    .vld_o(vld1), .x_o(x1), .x3_o(x3)
  );

  scfir_private #(.DW(DW), .PW(PW)) u_private (
    .clk(clk), .rst(rst), .adv(adv),
    .vld_i(vld1), .x_i(x1), .x3_i(x3),
    .vld_o(vld3), .prod_o(prods)
  );

  scfir_taps #(.PW(PW), .AW(AW)) u_taps (
    .clk(clk), .rst(rst), .adv(adv),
    .vld_i(vld3), .prod_i(prods),
    .vld_o(out_valid), .y_o(out_data)
  );
endmodule

// File: tb/tb_shared_term_fir.sv
`timescale 1ns/1ps
module tb_shared_term_fir;
  localparam int DW = 12;
  localparam int AW = 24;
  localparam int NT = 11;
  localparam int H [NT] = '{2, 7, 18, 34, 50, 57, 50, 34, 18, 7, 2};
  localparam int VEC_N = 22;
  localparam int VEC_IN  [VEC_N] = '{1,0,0,0,0,0,0,0,0,0,0, 1,1,1,1,1,1,1,1,1,1,1};
  localparam int VEC_EXP [VEC_N] = '{2,7,18,34,50,57,50,34,18,7,2,
                                     2,9,27,61,111,168,218,252,270,277,279};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [AW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int hist [NT];
  int exp_q [$];
  string tag_q [$];
  bit last_out_fire = 0;
  bit prev_stall = 0;
  logic [AW-1:0] prev_data = '0;
  bit use_table = 0;
  int table_val = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shared_term_fir dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int model_push(input int x);
    int s;
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    s = 0;
    for (int k = 0; k < NT; k++) s += H[k] * hist[k];
    return s;
  endfunction

  task automatic cycle(input bit iv, input int xv, input bit ordy, input string req);
    int e, m;
    string t;
    in_valid  = iv;
    in_data   = DW'(xv);
    out_ready = ordy;
    #1;
    last_out_fire = 0;
    if (prev_stall) begin
      check(out_valid == 1'b1, "R6", int'(out_valid), 1);
      check(out_data == prev_data, "R6", int'($signed(out_data)), int'($signed(prev_data)));
    end
    check(in_ready == (!out_valid || out_ready), "R6", int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      last_out_fire = 1;
      if (exp_q.size() == 0) begin
        check(0, "R5", int'($signed(out_data)), -1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (in_valid && in_ready) begin
      m = model_push(xv);
      exp_q.push_back(use_table ? table_val : m);
      tag_q.push_back(req);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    exp_q.delete();
    tag_q.delete();
    prev_stall = 0;
    #1;
    check(out_valid == 1'b0, "R7", int'(out_valid), 0);
    check(out_data == '0, "R7", int'($signed(out_data)), 0);
    check(in_ready == 1'b1, "R7", int'(in_ready), 1);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) cycle(0, 0, 1, "R5");
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
  endtask

  initial begin
    int lat;
    @(negedge clk);
    do_reset();

    // Table: impulse (R9) then step (R1)
    use_table = 1;
    for (int i = 0; i < VEC_N; i++) begin
      table_val = VEC_EXP[i];
      cycle(1, VEC_IN[i], 1, (i < NT) ? "R9" : "R1");
    end
    use_table = 0;
    drain();

    // R4: latency of a lone sample into an empty pipeline
    do_reset();
    cycle(1, 5, 1, "R4");
    lat = 0;
    do begin
      cycle(0, 0, 1, "R4");
      lat++;
    end while (!last_out_fire && lat < 12);
    check(lat == 4, "R4", lat, 4);

    // R8: full-scale positive and negative runs
    do_reset();
    for (int i = 0; i < NT; i++) cycle(1, 2047, 1, "R8");
    for (int i = 0; i < NT; i++) cycle(1, -2048, 1, "R8");
    for (int i = 0; i < 12; i++) cycle(1, (i % 2) ? 2047 : -2048, 1, "R8");
    drain();

    // R5: random samples with idle input cycles
    for (int i = 0; i < 600; i++)
      cycle(($urandom_range(0, 2) != 0), int'($urandom_range(0, 4095)) - 2048, 1, "R5");
    drain();

    // R6 and R1: random samples under random back-pressure
    for (int i = 0; i < 1500; i++)
      cycle(($urandom_range(0, 3) != 0), int'($urandom_range(0, 4095)) - 2048,
            ($urandom_range(0, 2) != 0), "R1");
    drain();

    // R7: reset with results in flight, then a fresh impulse
    for (int i = 0; i < 8; i++) cycle(1, 100, 0, "R7");
    do_reset();
    for (int i = 0; i < NT; i++) cycle(1, (i == 0) ? 1 : 0, 1, "R7");
    drain();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule